// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port with an APB slave register interface. Software sets each pin's direction. It can also hand any pin to an alternate hardware source, which then drives both the pin level and its output enable. The port reports input events on a single combined interrupt line.

Data access uses the address as a bit mask. The word offset inside the data window selects which pins a read returns and which pins a write may change. Software can therefore set or clear one pin in a single write, with no read-modify-write and no race against other agents driving the same port. Inputs are synchronized through two flops before any edge or level detection. Each pin has its own choice of edge or level sensing, polarity, both-edge triggering and enable. Edge events stay latched until software clears them.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every register reads 0. pin_oe_o, pin_o and irq_o are all 0, so all pins are inputs, interrupts are masked and software mode is selected.
- R2: A write with paddr_i[11:10]=0 is a data write. Its mask is paddr_i[9:2], where mask bit k is pin k. A data bit whose mask bit is 1 takes pwdata_i bit k. Every other data bit keeps its value. For a pin in software mode, pin_o bit k is data bit k.
- R3: A read with paddr_i[11:10]=0 returns 0 in every bit whose mask bit is 0. A bit whose mask bit is 1 returns the data bit if that pin's direction bit is 1. Otherwise it returns the pin input, seen two clock edges after it changes.
- R4: The direction register is at 0x400. A bit set to 1 makes that pin an output. For a pin in software mode, pin_oe_o bit k equals direction bit k.
- R5: The mode register is at 0x420. A bit set to 1 makes pin_o and pin_oe_o for that pin follow alt_out_i and alt_oe_i. A bit set to 0 leaves the pin under software control.
- R6: A sense bit (0x404) of 0 selects edge sensing. A both-edges bit (0x408) of 1 catches any change. Otherwise the polarity bit (0x40C) selects rising edges when 1 and falling edges when 0. The raw status bit (0x414) sets three edges after the pin changes and stays set.
- R7: Writing to 0x41C clears each edge-mode raw status bit written as 1. Bits written as 0 are untouched. This register reads as 0.
- R8: With sense bit 1, the raw status bit follows the pin level: 1 while the synchronized input equals the polarity bit. Writes to 0x41C do not affect it.
- R9: Masked status (0x418) is raw status AND interrupt enable (0x410). irq_o is 1 exactly when any masked status bit is 1.
- R10: The configuration registers read back in bits [7:0], and bits [31:8] read 0. Reads of unmapped offsets (any offset at 0x424 or above) return 0, and writes to them change nothing.
- R11: pready_o is always 1. A write takes effect on the clock edge that ends its access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| pin_i | input | 8 | Pin input levels (asynchronous) |
| alt_out_i | input | 8 | Alternate hardware drive values |
| alt_oe_i | input | 8 | Alternate hardware output enables |
| pin_o | output | 8 | Pin drive values |
| pin_oe_o | output | 8 | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
A corrupted data register appears on pin_o right after the masked write that should have left a bit alone. It also appears on the first full-mask read. A wrong synchronizer depth or edge comparison moves or drops the raw status bit, which appears on the raw-status read three edges after a pin change. Sticky bits that decay, or clear bits that reach the wrong pins, show up on the next raw-status read and on irq_o within the same cycle as the masked status. Decoding errors show as nonzero data on unmapped offsets, or as a register that reads back a value nobody wrote.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned NPIN    = 8;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned WIN_LSB = NPIN + 2;
  localparam int unsigned WIN_W   = ADDR_W - WIN_LSB;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH, SEL_POL,
    SEL_IE, SEL_RAW, SEL_MIS, SEL_CLR, SEL_MODE
  } reg_sel_e;

  typedef struct packed {
    logic [NPIN-1:0] dir;
    logic [NPIN-1:0] sense;
    logic [NPIN-1:0] both;
    logic [NPIN-1:0] pol;
    logic [NPIN-1:0] ie;
    logic [NPIN-1:0] mode;
  } cfg_t;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[ADDR_W-1:WIN_LSB] == WIN_W'(0)) begin
      s = SEL_DATA;
    end else if (a[ADDR_W-1:WIN_LSB] == WIN_W'(1)) begin
      case (a[WIN_LSB-1:2])
        NPIN'(0): s = SEL_DIR;
        NPIN'(1): s = SEL_SENSE;
        NPIN'(2): s = SEL_BOTH;
        NPIN'(3): s = SEL_POL;
        NPIN'(4): s = SEL_IE;
        NPIN'(5): s = SEL_RAW;
        NPIN'(6): s = SEL_MIS;
        NPIN'(7): s = SEL_CLR;
        NPIN'(8): s = SEL_MODE;
        default:  s = SEL_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [WIDTH-1:0] stage_q [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s <= STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s <= STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = stage_q[STAGES];
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic prev_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_o
);
  logic rise, fall, edge_hit, level_hit, raw_d, raw_q;

  assign rise      = sync_i & ~prev_i;
  assign fall      = ~sync_i & prev_i;
  assign edge_hit  = both_i ? (rise | fall) : (pol_i ? rise : fall);
  assign level_hit = (sync_i == pol_i);
  // a fresh edge wins over a clear in the same cycle
  assign raw_d     = sense_i ? level_hit : (edge_hit | (raw_q & ~clr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= raw_d;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/gpio_apb_regs.sv
module gpio_apb_regs
  import gpio_mask_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  input  logic [NPIN-1:0]   pin_sync_i,
  input  logic [NPIN-1:0]   raw_i,
  output cfg_t              cfg_o,
  output logic [NPIN-1:0]   data_o,
  output logic [NPIN-1:0]   clr_o,
  output logic [DATA_W-1:0] prdata_o
);
  reg_sel_e        sel;
  logic            wr_en, rd_en;
  logic [NPIN-1:0] mask, wd, rd_val, data_view;
  logic [NPIN-1:0] data_q;
  cfg_t            cfg_q;
  logic            unused_bits;

  assign sel   = decode_addr(paddr_i);
  assign wr_en = psel_i & penable_i & pwrite_i;
  assign rd_en = psel_i & ~pwrite_i;
  assign mask  = paddr_i[WIN_LSB-1:2];
  assign wd    = pwdata_i[NPIN-1:0];
  assign unused_bits = ^{pwdata_i[DATA_W-1:NPIN], paddr_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cfg_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA:  data_q     <= (data_q & ~mask) | (wd & mask);
        SEL_DIR:   cfg_q.dir   <= wd;
        SEL_SENSE: cfg_q.sense <= wd;
        SEL_BOTH:  cfg_q.both  <= wd;
        SEL_POL:   cfg_q.pol   <= wd;
        SEL_IE:    cfg_q.ie    <= wd;
        SEL_MODE:  cfg_q.mode  <= wd;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en && sel == SEL_CLR) ? wd : '0;

  // output pins read back the software value, inputs the synchronized level
  assign data_view = (cfg_q.dir & data_q) | (~cfg_q.dir & pin_sync_i);

  always_comb begin
    case (sel)
      SEL_DATA:  rd_val = data_view & mask;
      SEL_DIR:   rd_val = cfg_q.dir;
      SEL_SENSE: rd_val = cfg_q.sense;
      SEL_BOTH:  rd_val = cfg_q.both;
      SEL_POL:   rd_val = cfg_q.pol;
      SEL_IE:    rd_val = cfg_q.ie;
      SEL_RAW:   rd_val = raw_i;
      SEL_MIS:   rd_val = raw_i & cfg_q.ie;
      SEL_MODE:  rd_val = cfg_q.mode;
      default:   rd_val = '0;
    endcase
  end

  assign prdata_o = rd_en ? {{(DATA_W-NPIN){1'b0}}, rd_val} : '0;
  assign cfg_o    = cfg_q;
  assign data_o   = data_q;
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [NPIN-1:0]   alt_out_i,
  input  logic [NPIN-1:0]   alt_oe_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic              irq_o
);
  cfg_t            cfg;
  logic [NPIN-1:0] data_sw, clr_vec, raw_vec, pin_sync, pin_prev;

  gpio_in_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync),
    .prev_o  (pin_prev)
  );

  gpio_apb_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .psel_i     (psel_i),
    .penable_i  (penable_i),
    .pwrite_i   (pwrite_i),
    .paddr_i    (paddr_i),
    .pwdata_i   (pwdata_i),
    .pin_sync_i (pin_sync),
    .raw_i      (raw_vec),
    .cfg_o      (cfg),
    .data_o     (data_sw),
    .clr_o      (clr_vec),
    .prdata_o   (prdata_o)
  );

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    gpio_irq_cell i_irq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (pin_sync[k]),
      .prev_i  (pin_prev[k]),
      .sense_i (cfg.sense[k]),
      .both_i  (cfg.both[k]),
      .pol_i   (cfg.pol[k]),
      .clr_i   (clr_vec[k]),
      .raw_o   (raw_vec[k])
    );
    assign pin_o[k]    = cfg.mode[k] ? alt_out_i[k] : data_sw[k];
    assign pin_oe_o[k] = cfg.mode[k] ? alt_oe_i[k]  : cfg.dir[k];
  end

  assign irq_o    = |(raw_vec & cfg.ie);
  assign pready_o = 1'b1;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
  import gpio_mask_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [DATA_W-1:0] prdata_o,
  input logic [NPIN-1:0]   pin_o,
  input logic              irq_o,
  input logic [NPIN-1:0]   raw_i,
  input logic [NPIN-1:0]   sense_i,
  input logic [NPIN-1:0]   ie_i,
  input logic [NPIN-1:0]   mode_i
);
  logic            in_data, unmapped, wr_acc, rd_acc;
  logic [NPIN-1:0] mask, clr_w;

  assign in_data  = (paddr_i[ADDR_W-1:WIN_LSB] == WIN_W'(0));
  assign unmapped = !in_data && !((paddr_i[ADDR_W-1:WIN_LSB] == WIN_W'(1))
                                  && (paddr_i[WIN_LSB-1:2] <= NPIN'(8)));
  assign mask     = paddr_i[WIN_LSB-1:2];
  assign wr_acc   = psel_i & penable_i & pwrite_i;
  assign rd_acc   = psel_i & ~pwrite_i;
  assign clr_w    = (wr_acc && paddr_i == ADDR_W'('h41C)) ? '1 : '0;

  // R2: software pins outside the write mask do not move
  assert_masked_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && in_data) |=>
      (((pin_o ^ $past(pin_o)) & ~$past(mask) & ~$past(mode_i) & ~mode_i) == '0));

  // R3: unmasked data bits read as zero
  assert_masked_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && in_data) |-> ((prdata_o[NPIN-1:0] & ~mask) == '0 && prdata_o[DATA_W-1:NPIN] == '0));

  // R10: unmapped offsets read zero
  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && unmapped) |-> (prdata_o == '0));

  // R6: edge-mode status stays set unless a clear write was seen
  assert_edge_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(raw_i) & ~$past(sense_i) & ~$past(clr_w) & ~raw_i) == '0));

  // R9: interrupt needs at least one enabled pin
  assert_irq_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_i != '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .psel_i    (psel_i),
  .penable_i (penable_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .prdata_o  (prdata_o),
  .pin_o     (pin_o),
  .irq_o     (irq_o),
  .raw_i     (raw_vec),
  .sense_i   (cfg.sense),
  .ie_i      (cfg.ie),
  .mode_i    (cfg.mode)
);

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  logic        clk, rst_n;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, irq;
  logic [7:0]  pin_in, alt_out, alt_oe, pin_out, pin_oe;
  int checks, errors;
  logic [31:0] rv;
  logic [7:0]  model;

  gpio_mask_port i_gpio_mask_port (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pin_i(pin_in), .alt_out_i(alt_out), .alt_oe_i(alt_oe),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    pin_in = '0; alt_out = '0; alt_oe = '0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(2);
    #1;
    // R1 reset state
    chk("R1 pin_oe", {24'b0, pin_oe}, 0);
    chk("R1 pin_o", {24'b0, pin_out}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R11 pready", {31'b0, pready}, 1);
    for (int a = 'h400; a <= 'h420; a += 4) begin
      rd(12'(a), rv); chk("R1 reg reset", rv, 0);
    end
    rd(12'h3FC, rv); chk("R1 data reset", rv, 0);

    // R2 sweep every mask with outputs enabled
    wr(12'h400, 32'hFF);
    chk("R4 oe follows dir", {24'b0, pin_oe}, 32'hFF);
    model = '0;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] d;
      d = 8'((m * 37 + 11) & 255);
      wr({2'b00, 8'(m), 2'b00}, {24'hABCDEF, d});
      model = (model & ~8'(m)) | (d & 8'(m));
      #1 chk("R2 masked write", {24'b0, pin_out}, {24'b0, model});
    end
    // R3 read masking over output pins
    for (int m = 0; m < 256; m++) begin
      rd({2'b00, 8'(m), 2'b00}, rv);
      chk("R3 read output mask", rv, {24'b0, model & 8'(m)});
    end
    // R3 read masking over input pins
    wr(12'h400, 32'h0);
    pin_in = 8'hA5;
    idle(3);
    for (int m = 0; m < 256; m++) begin
      rd({2'b00, 8'(m), 2'b00}, rv);
      chk("R3 read input mask", rv, {24'b0, 8'hA5 & 8'(m)});
    end
    // R3 mixed direction
    wr(12'h400, 32'h0F);
    pin_in = 8'h5A;
    idle(3);
    rd(12'h3FC, rv);
    chk("R3 mixed dir", rv, {24'b0, (model & 8'h0F) | (8'h5A & 8'hF0)});
    wr(12'h400, 32'h0);

    // R6 edge sensing across both/polarity settings
    for (int c = 0; c < 4; c++) begin
      logic [7:0] bo, po;
      bo = c[1] ? 8'hFF : 8'h00;
      po = c[0] ? 8'hFF : 8'h00;
      wr(12'h408, {24'b0, bo});
      wr(12'h40C, {24'b0, po});
      pin_in = 8'h00;
      idle(5);
      wr(12'h41C, 32'hFF);
      rd(12'h414, rv); chk("R7 clear all", rv, 0);
      pin_in = 8'hFF;
      idle(5);
      rd(12'h414, rv); chk("R6 rising", rv, {24'b0, bo | po});
      wr(12'h41C, 32'hFF);
      pin_in = 8'h00;
      idle(5);
      rd(12'h414, rv); chk("R6 falling", rv, {24'b0, bo | ~po});
    end
    idle(10);
    rd(12'h414, rv); chk("R6 sticky", rv, 32'hFF);
    // R7 partial clear
    wr(12'h41C, 32'h0F);
    rd(12'h414, rv); chk("R7 partial clear", rv, 32'hF0);
    wr(12'h41C, 32'h00);
    rd(12'h414, rv); chk("R7 zero write", rv, 32'hF0);
    rd(12'h41C, rv); chk("R7 clear reads 0", rv, 0);

    // R9 masked status and irq
    wr(12'h410, 32'h5A);
    rd(12'h418, rv); chk("R9 masked", rv, 32'h50);
    #1 chk("R9 irq high", {31'b0, irq}, 1);
    wr(12'h410, 32'h0F);
    rd(12'h418, rv); chk("R9 masked off", rv, 0);
    #1 chk("R9 irq low", {31'b0, irq}, 0);
    wr(12'h410, 32'h0);

    // R8 level sensing
    wr(12'h404, 32'hFF);
    wr(12'h40C, 32'h0F);
    pin_in = 8'h3C;
    idle(5);
    rd(12'h414, rv); chk("R8 level", rv, 32'hCC);
    wr(12'h41C, 32'hFF);
    rd(12'h414, rv); chk("R8 clear ignored", rv, 32'hCC);
    pin_in = 8'hC3;
    idle(5);
    rd(12'h414, rv); chk("R8 level follows", rv, 32'h33);
    wr(12'h404, 32'h0);
    wr(12'h41C, 32'hFF);
    rd(12'h414, rv); chk("R7 clear after level", rv, 0);

    // R5 alternate mode
    wr(12'h400, 32'hFFFF_FF0F);
    wr(12'h3FC, 32'h33);
    wr(12'h420, 32'hF0);
    alt_out = 8'hAA; alt_oe = 8'h55;
    #1;
    chk("R5 pin_o mix", {24'b0, pin_out}, 32'hA3);
    chk("R5 pin_oe mix", {24'b0, pin_oe}, 32'h5F);
    alt_out = 8'h55; alt_oe = 8'hAA;
    #1;
    chk("R5 pin_o follows alt", {24'b0, pin_out}, 32'h53);
    chk("R4 pin_oe sw bits", {24'b0, pin_oe}, 32'hAF);

    // R10 readback and unmapped
    rd(12'h400, rv); chk("R10 dir readback", rv, 32'h0F);
    rd(12'h420, rv); chk("R10 mode readback", rv, 32'hF0);
    rd(12'h40C, rv); chk("R10 pol readback", rv, 32'h0F);
    rd(12'h408, rv); chk("R10 both readback", rv, 32'hFF);
    wr(12'h424, 32'hFF);
    wr(12'h800, 32'hFF);
    rd(12'h400, rv); chk("R10 unmapped write", rv, 32'h0F);
    rd(12'h424, rv); chk("R10 unmapped 424", rv, 0);
    rd(12'h800, rv); chk("R10 unmapped 800", rv, 0);
    rd(12'hFFC, rv); chk("R10 unmapped FFC", rv, 0);
    rd(12'h43C, rv); chk("R10 unmapped 43C", rv, 0);
    chk("R11 pready steady", {31'b0, pready}, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule